// File: doc/BRIEF.md
# Read-Address Command Sequence Detector

This block sits beside a memory interface and watches its accesses for a fixed run of reads that asks for a command. An access is taken each time the active-low chip enable goes from high to low, as seen in the system clock domain. At that moment the address and the write flag are sampled. Five reads to fixed addresses must come in a fixed order. A sixth read then picks the command: one address asks for a store and another asks for a recall.

The block only produces requests. It drives a one-cycle `store_req` or `recall_req` pulse, which a transfer controller consumes. That controller holds `busy` high while it works. While `busy` is high, the detector ignores the bus and discards any partial progress. Any write, any read that breaks the order, and any repeated access where a single step was expected all cancel the attempt in progress.

Top module: `cmd_seq_detect`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `store_req` and `recall_req` are low, and progress is zero. After reset, a lone sixth-step read produces no request.
- R2: A step is taken only in the clock cycle where `ce_n` is sampled low after being sampled high. Holding `ce_n` low for several cycles counts as one access, whatever the address does meanwhile.
- R3: Reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0 in that order, followed by a read of 0x0F0F, raise `store_req` for exactly one cycle. The pulse comes in the cycle after the clock edge that samples the sixth falling edge.
- R4: The same five reads followed by a read of 0x0F0E raise `recall_req` for one cycle, with the same timing as R3.
- R5: A read whose address is not the one expected next cancels the attempt, and no request follows. This includes a wrong sixth address.
- R6: An access with `we_n` low cancels the attempt even when its address matches the expected one. Writes never advance progress.
- R7: Reading the same address twice in a row where one step was expected cancels the attempt.
- R8: A read of 0x0000 that cancels an attempt counts as the first step of a new attempt.
- R9: While `busy` is high, accesses are ignored and progress returns to zero. Steps completed before `busy` rose do not count afterwards.
- R10: `store_req` and `recall_req` are never high together, and neither is high for two cycles running.
- R11: After a request, progress is zero, so a new request needs all six reads again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Active-low chip enable; its falling edge marks an access |
| we_n | input | 1 | Active-low write enable, sampled with the access (high = read) |
| addr | input | 13 | Access address, sampled with the access |
| busy | input | 1 | Transfer in progress; suspends and clears detection |
| store_req | output | 1 | One-cycle store command pulse |
| recall_req | output | 1 | One-cycle recall command pulse |

## Verification
The bench targets these corner cases:
- Each access is held low for several cycles with a moving address. A level-sensitive design would advance on every cycle and fire early or abort.
- An address is repeated, a matching write is inserted, and the sixth address is wrong. A design that fails to abort would issue a spurious request.
- A cancelling read of 0x0000 is followed by the rest of the pattern. A design that resets to idle would miss this store.
- Part of the pattern is given before `busy` rises and the rest after it falls. A design that keeps progress across a transfer would issue a request here.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_STORE  = 2'd1,
    CMD_RECALL = 2'd2
  } cmd_t;
endpackage

// File: rtl/cmd_edge_detect.sv
module cmd_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic busy,
  output logic strobe
);
  logic ce_q;

  // previous sample of chip enable; reset to deasserted so no false edge
  always_ff @(posedge clk) begin
    if (rst) ce_q <= 1'b1;
    else     ce_q <= ce_n;
  end

  assign strobe = ce_q & ~ce_n & ~busy;
endmodule

// File: rtl/cmd_pattern_match.sv
module cmd_pattern_match #(
  parameter int ADDR_W = 13,
  parameter int PRE_LEN = 5,
  parameter logic [PRE_LEN*ADDR_W-1:0] PRE_SEQ = '0,
  parameter logic [ADDR_W-1:0] STORE_ADDR = '0,
  parameter logic [ADDR_W-1:0] RECALL_ADDR = '0
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [PRE_LEN-1:0] hit_pre,
  output logic               hit_store,
  output logic               hit_recall
);
  for (genvar i = 0; i < PRE_LEN; i++) begin : g_cmp
    assign hit_pre[i] = (addr == PRE_SEQ[i*ADDR_W +: ADDR_W]);
  end

  assign hit_store  = (addr == STORE_ADDR);
  assign hit_recall = (addr == RECALL_ADDR);
endmodule

// File: rtl/cmd_seq_tracker.sv
module cmd_seq_tracker
  import cmd_seq_pkg::*;
#(
  parameter int PRE_LEN = 5,
  localparam int STEP_W = $clog2(PRE_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strobe,
  input  logic               is_read,
  input  logic               busy,
  input  logic [PRE_LEN-1:0] hit_pre,
  input  logic               hit_store,
  input  logic               hit_recall,
  output logic               store_req,
  output logic               recall_req
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(PRE_LEN);
  localparam logic [STEP_W-1:0] ONE  = STEP_W'(1);

  logic [STEP_W-1:0] step, step_nx;
  cmd_t              cmd_nx;
  logic              expect_hit;

  always_comb begin
    expect_hit = 1'b0;
    for (int i = 0; i < PRE_LEN; i++)
      if (step == STEP_W'(i)) expect_hit = hit_pre[i];
  end

  always_comb begin
    step_nx = step;
    cmd_nx  = CMD_NONE;
    if (busy) begin
      step_nx = '0;
    end else if (strobe) begin
      if (!is_read) begin
        step_nx = '0;
      end else if (step == LAST) begin
        if (hit_store) begin
          cmd_nx  = CMD_STORE;
          step_nx = '0;
        end else if (hit_recall) begin
          cmd_nx  = CMD_RECALL;
          step_nx = '0;
        end else begin
          step_nx = hit_pre[0] ? ONE : '0;
        end
      end else if (expect_hit) begin
        step_nx = step + ONE;
      end else begin
        // a cancelling read of the first address opens a new attempt
        step_nx = hit_pre[0] ? ONE : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step       <= '0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      step       <= step_nx;
      store_req  <= (cmd_nx == CMD_STORE);
      recall_req <= (cmd_nx == CMD_RECALL);
    end
  end
endmodule

// File: rtl/cmd_seq_detect.sv
module cmd_seq_detect #(
  parameter int ADDR_W = 13,
  parameter int PRE_LEN = 5,
  parameter logic [PRE_LEN*ADDR_W-1:0] PRE_SEQ =
    {13'h10F0, 13'h1FFF, 13'h0AAA, 13'h1555, 13'h0000},
  parameter logic [ADDR_W-1:0] STORE_ADDR  = 13'h0F0F,
  parameter logic [ADDR_W-1:0] RECALL_ADDR = 13'h0F0E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output logic              store_req,
  output logic              recall_req
);
  logic               strobe;
  logic [PRE_LEN-1:0] hit_pre;
  logic               hit_store, hit_recall;

  cmd_edge_detect u_edge (
    .clk    (clk),
    .rst    (rst),
    .ce_n   (ce_n),
    .busy   (busy),
    .strobe (strobe)
  );

  cmd_pattern_match #(
    .ADDR_W      (ADDR_W),
    .PRE_LEN     (PRE_LEN),
    .PRE_SEQ     (PRE_SEQ),
    .STORE_ADDR  (STORE_ADDR),
    .RECALL_ADDR (RECALL_ADDR)
  ) u_match (
    .addr       (addr),
    .hit_pre    (hit_pre),
    .hit_store  (hit_store),
    .hit_recall (hit_recall)
  );

  cmd_seq_tracker #(
    .PRE_LEN (PRE_LEN)
  ) u_track (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .is_read    (we_n),
    .busy       (busy),
    .hit_pre    (hit_pre),
    .hit_store  (hit_store),
    .hit_recall (hit_recall),
    .store_req  (store_req),
    .recall_req (recall_req)
  );
endmodule

// File: rtl/cmd_seq_detect_chk.sv
module cmd_seq_detect_chk #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] STORE_ADDR  = 13'h0F0F,
  parameter logic [ADDR_W-1:0] RECALL_ADDR = 13'h0F0E
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              store_req,
  input logic              recall_req
);
  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(store_req && recall_req));

  p_store_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    store_req |=> !store_req);

  p_recall_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    recall_req |=> !recall_req);

  p_store_cause_r3: assert property (@(posedge clk) disable iff (rst)
    store_req |-> ($past(ce_n, 2) && !$past(ce_n) && $past(we_n)
                   && !$past(busy) && $past(addr) == STORE_ADDR));

  p_recall_cause_r4: assert property (@(posedge clk) disable iff (rst)
    recall_req |-> ($past(ce_n, 2) && !$past(ce_n) && $past(we_n)
                    && !$past(busy) && $past(addr) == RECALL_ADDR));

  p_write_no_cmd_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(we_n) |-> (!store_req && !recall_req));

  p_busy_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> (!store_req && !recall_req));

  p_level_once_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(!ce_n, 2) && !$past(ce_n)) |-> (!store_req && !recall_req));
endmodule

bind cmd_seq_detect cmd_seq_detect_chk #(
  .ADDR_W      (ADDR_W),
  .STORE_ADDR  (STORE_ADDR),
  .RECALL_ADDR (RECALL_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ce_n       (ce_n),
  .we_n       (we_n),
  .addr       (addr),
  .busy       (busy),
  .store_req  (store_req),
  .recall_req (recall_req)
);

// File: tb/test_cmd_seq_detect.sv
module test_cmd_seq_detect;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1;
  logic        we_n = 1'b1;
  logic [12:0] addr = '0;
  logic        busy = 1'b0;
  logic        store_req, recall_req;

  int checks = 0;
  int errors = 0;
  int n_store = 0;
  int n_recall = 0;
  bit done = 1'b0;

  localparam logic [12:0] PAT [5] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0};

  always #5 clk = ~clk;

  cmd_seq_detect i_cmd_seq_detect (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .busy(busy), .store_req(store_req), .recall_req(recall_req)
  );

  // behavioural reference model
  int m_step;
  bit m_prev;
  bit exp_s, exp_r;
  always @(posedge clk) begin
    if (rst) begin
      m_step = 0; m_prev = 1; exp_s = 0; exp_r = 0;
    end else begin
      exp_s = 0; exp_r = 0;
      if (busy) m_step = 0;
      else if (m_prev && !ce_n) begin
        if (!we_n) m_step = 0;
        else if (m_step == 5) begin
          if (addr == 13'h0F0F) begin exp_s = 1; m_step = 0; end
          else if (addr == 13'h0F0E) begin exp_r = 1; m_step = 0; end
          else m_step = (addr == 13'h0000) ? 1 : 0;
        end else if (addr == PAT[m_step]) m_step++;
        else m_step = (addr == 13'h0000) ? 1 : 0;
      end
      m_prev = ce_n;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks += 2;
      if (store_req !== exp_s) begin
        errors++;
        $display("FAIL R3 store_req at %0t: got %b exp %b", $time, store_req, exp_s);
      end
      if (recall_req !== exp_r) begin
        errors++;
        $display("FAIL R4 recall_req at %0t: got %b exp %b", $time, recall_req, exp_r);
      end
      if (store_req === 1'b1) n_store++;
      if (recall_req === 1'b1) n_recall++;
    end
  end

  task automatic access(input logic [12:0] a, input bit wr, input int hold);
    @(negedge clk);
    ce_n = 1'b0; addr = a; we_n = ~wr;
    repeat (hold) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [12:0] a);
    access(a, 1'b0, 1);
  endtask

  task automatic prefix();
    for (int i = 0; i < 5; i++) rd(PAT[i]);
  endtask

  task automatic settle_and_check(input string tag, input int es, input int er);
    repeat (4) @(negedge clk);
    checks++;
    if (n_store != es || n_recall != er) begin
      errors++;
      $display("FAIL %s: got store=%0d recall=%0d exp store=%0d recall=%0d",
               tag, n_store, n_recall, es, er);
    end
    n_store = 0; n_recall = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (store_req !== 1'b0 || recall_req !== 1'b0) begin
      errors++;
      $display("FAIL R1 outputs in reset: got %b%b exp 00", store_req, recall_req);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (store_req !== 1'b0 || recall_req !== 1'b0) begin
      errors++;
      $display("FAIL R1 outputs after reset: got %b%b exp 00", store_req, recall_req);
    end
    rd(13'h0F0F);
    settle_and_check("R1 lone last step", 0, 0);

    prefix(); rd(13'h0F0F);
    settle_and_check("R3 store sequence", 1, 0);
    rd(13'h0F0F);
    settle_and_check("R11 progress cleared after request", 0, 0);

    prefix(); rd(13'h0F0E);
    settle_and_check("R4 recall sequence", 0, 1);

    rd(PAT[0]); rd(PAT[1]); rd(13'h1234); rd(PAT[3]); rd(PAT[4]); rd(13'h0F0F);
    settle_and_check("R5 wrong read aborts", 0, 0);
    prefix(); rd(13'h0F0D);
    settle_and_check("R5 wrong sixth address", 0, 0);

    rd(PAT[0]); access(PAT[1], 1'b1, 1); rd(PAT[2]); rd(PAT[3]); rd(PAT[4]); rd(13'h0F0F);
    settle_and_check("R6 write aborts", 0, 0);

    rd(PAT[0]); rd(PAT[1]); rd(PAT[1]); rd(PAT[2]); rd(PAT[3]); rd(PAT[4]); rd(13'h0F0F);
    settle_and_check("R7 double access aborts", 0, 0);

    rd(PAT[0]); rd(PAT[1]); rd(PAT[0]); rd(PAT[1]); rd(PAT[2]); rd(PAT[3]); rd(PAT[4]);
    rd(13'h0F0F);
    settle_and_check("R8 cancelling first address restarts", 1, 0);

    for (int i = 0; i < 5; i++) access(PAT[i], 1'b0, 4);
    access(13'h0F0E, 1'b0, 4);
    settle_and_check("R2 held enable counts once", 0, 1);

    // hold enable low while the address walks through the rest of the pattern
    @(negedge clk);
    ce_n = 1'b0; addr = PAT[0];
    for (int i = 1; i < 5; i++) begin @(negedge clk); addr = PAT[i]; end
    @(negedge clk); addr = 13'h0F0F;
    @(negedge clk); ce_n = 1'b1;
    settle_and_check("R2 address change without edge", 0, 0);

    rd(PAT[0]); rd(PAT[1]); rd(PAT[2]);
    @(negedge clk); busy = 1'b1;
    rd(PAT[3]); rd(PAT[4]); rd(13'h0F0F);
    @(negedge clk); busy = 1'b0;
    settle_and_check("R9 accesses ignored while busy", 0, 0);
    rd(PAT[3]); rd(PAT[4]); rd(13'h0F0F);
    settle_and_check("R9 progress dropped across busy", 0, 0);
    prefix(); rd(13'h0F0F);
    settle_and_check("R9 detection resumes after busy", 1, 0);

    prefix(); rd(13'h0F0F); prefix(); rd(13'h0F0E);
    settle_and_check("R10 back to back commands", 1, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule